// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address presented to a synchronous burst memory during bursts of up to four beats. An address-strobe cycle captures a full external address. Two strobes can start a burst: one driven by a processor and one driven by a cache controller. Either strobe counts only while the active-low chip enable is asserted. After the capture, the upper address bits stay frozen. The two low bits come from an internal two-bit beat counter, which steps only on cycles where the active-low advance input is asserted.

The beat counter is combined with the captured low bits in one of two orders. In linear order the beat count is added to the captured low bits modulo four. In interleaved order the beat count is XORed with them. A mode input picks the order. The mode value is captured together with the address, so one burst always keeps a single order. All inputs are sampled on the rising clock edge, and the outputs change only after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `addr_out` is 0 and `beat` is 0.
- R2: A load happens when `ce_n` is 0 and either `ads_proc_n` or `ads_cache_n` is 0. After the edge that samples the load, `addr_out` equals the sampled `addr_in` and `beat` is 0.
- R3: When `ce_n` is 1, both strobes are ignored. With `adv_n` high, `addr_out` and `beat` are left unchanged.
- R4: A load takes priority over an advance sampled in the same cycle. The beat returns to 0 and does not step.
- R5: When no load happens and `adv_n` is 0, `beat` increments by one modulo 4 at the edge.
- R6: When no load happens and `adv_n` is 1, `addr_out` and `beat` hold their values.
- R7: When `mode` is 0 at load (linear), the low two bits of `addr_out` equal (start + beat) mod 4. For example, start 1 gives 1,2,3,0.
- R8: When `mode` is 1 at load (interleaved), the low two bits of `addr_out` equal start XOR beat. For example, start 1 gives 1,0,3,2.
- R9: The order is taken from `mode` only at a load. Changing `mode` during a burst has no effect on `addr_out`.
- R10: Between loads, `addr_out[AW-1:2]` never changes. After four advances the low bits return to the start value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low; gates both strobes |
| ads_proc_n | input | 1 | Processor-side address strobe, active low |
| ads_cache_n | input | 1 | Cache-controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_in | input | AW | External address captured on load |
| addr_out | output | AW | Current burst address |
| beat | output | 2 | Beat index within the burst |

## Verification
The bound assertions check the cycle-to-cycle rules on every cycle:
- the capture and beat clear after a load, including when an advance is sampled in the same cycle;
- the single-step increment of the beat on an advance;
- the hold when neither a load nor an advance is sampled;
- the frozen upper address bits between loads.

The actual low-bit values for each order, the wrap back to the start after four beats, and the fact that a mid-burst mode change has no effect all depend on what was captured several cycles earlier. Only the bench's reference model shows these, through directed bursts and random traffic.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

    // Burst context captured at a load: the order and the starting low bits
    typedef struct packed {
        burst_order_e order;
        beat_t        start;
    } burst_ctx_t;

    function automatic beat_t burst_low(input burst_ctx_t ctx, input beat_t cnt);
        beat_t res;
        if (ctx.order == ORDER_INTERLEAVE)
            res = ctx.start ^ cnt;
        else
            res = ctx.start + cnt;
        return res;
    endfunction

endpackage

// File: rtl/burst_load_gate.sv
module burst_load_gate #(
    parameter int N_STROBES = 2
) (
    input  logic                 ce_n,
    input  logic [N_STROBES-1:0] strobe_n,
    output logic                 load
);
    logic [N_STROBES-1:0] hit;

    for (genvar i = 0; i < N_STROBES; i++) begin : g_strobe
        assign hit[i] = ~strobe_n[i] & ~ce_n;
    end

    assign load = |hit;
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  adv_n,
    output beat_t cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= '0;
        else if (!adv_n)
            cnt <= cnt + beat_t'(1);
    end
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
    import burst_seq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               mode,
    input  logic [AW-1:0]      addr_in,
    output logic [AW-BEAT_W-1:0] upper,
    output burst_ctx_t         ctx
);
    localparam int UPPER_W = AW - BEAT_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper     <= '0;
            ctx.order <= ORDER_LINEAR;
            ctx.start <= '0;
        end else if (load) begin
            upper     <= addr_in[AW-1 -: UPPER_W];
            ctx.order <= burst_order_e'(mode);
            ctx.start <= addr_in[BEAT_W-1:0];
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          ads_proc_n,
    input  logic          ads_cache_n,
    input  logic          adv_n,
    input  logic          mode,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic [1:0]    beat
);
    localparam int UPPER_W = AW - BEAT_W;

    logic               load;
    beat_t              cnt;
    logic [UPPER_W-1:0] upper;
    burst_ctx_t         ctx;

    burst_load_gate #(.N_STROBES(2)) u_gate (
        .ce_n     (ce_n),
        .strobe_n ({ads_cache_n, ads_proc_n}),
        .load     (load)
    );

    burst_beat_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .adv_n (adv_n),
        .cnt   (cnt)
    );

    burst_addr_reg #(.AW(AW)) u_areg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .mode    (mode),
        .addr_in (addr_in),
        .upper   (upper),
        .ctx     (ctx)
    );

    assign addr_out = {upper, burst_low(ctx, cnt)};
    assign beat     = cnt;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          ce_n,
    input logic          ads_proc_n,
    input logic          ads_cache_n,
    input logic          adv_n,
    input logic [AW-1:0] addr_in,
    input logic [AW-1:0] addr_out,
    input logic [1:0]    beat
);
    logic armed;
    logic ld;

    always_ff @(posedge clk) armed <= !rst;

    assign ld = !ce_n && (!ads_proc_n || !ads_cache_n);

    // R2, R4
    load_capture_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ld |=> (addr_out == $past(addr_in)) && (beat == 2'd0));

    // R5
    beat_step_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (!ld && !adv_n) |=> beat == 2'($past(beat) + 2'd1));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (!ld && adv_n) |=> $stable(addr_out) && $stable(beat));

    // R3
    strobe_ignored_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (ce_n && adv_n) |=> $stable(addr_out));

    // R10
    upper_stable_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !ld |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) chk (
    .clk         (clk),
    .rst         (rst),
    .ce_n        (ce_n),
    .ads_proc_n  (ads_proc_n),
    .ads_cache_n (ads_cache_n),
    .adv_n       (adv_n),
    .addr_in     (addr_in),
    .addr_out    (addr_out),
    .beat        (beat)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, ads_proc_n = 1'b1, ads_cache_n = 1'b1;
    logic          adv_n = 1'b1, mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    // reference model state
    logic [AW-1:0] m_base = '0;
    int            m_beat = 0;
    bit            m_ilv = 0;

    always #5 clk = ~clk;

    burst_addr_seq #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .ads_proc_n(ads_proc_n),
        .ads_cache_n(ads_cache_n), .adv_n(adv_n), .mode(mode),
        .addr_in(addr_in), .addr_out(addr_out), .beat(beat)
    );

    function automatic logic [AW-1:0] exp_addr();
        int s = int'(m_base[1:0]);
        int lo = m_ilv ? (s ^ m_beat) : ((s + m_beat) % 4);
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] ea, input int eb);
        checks++;
        if (addr_out !== ea || beat !== 2'(eb)) begin
            fails++;
            $display("FAIL %s: addr_out=%h beat=%0d expected addr_out=%h beat=%0d",
                     tag, addr_out, beat, ea, eb);
        end
    endtask

    // drive at negedge, sample edge, check at following negedge
    task automatic step(input logic cen, input logic pn, input logic cn,
                        input logic an, input logic md, input logic [AW-1:0] a,
                        input string tag);
        bit ld;
        ce_n = cen; ads_proc_n = pn; ads_cache_n = cn; adv_n = an; mode = md; addr_in = a;
        @(posedge clk);
        ld = !cen && (!pn || !cn);
        if (ld) begin
            m_base = a; m_beat = 0; m_ilv = md;
        end else if (!an) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        check(tag, exp_addr(), m_beat);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                done = 1;
                fails++; checks++;
                $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", '0, 0);
        rst = 1'b0;
        step(1, 1, 1, 1, 0, 20'h0, "R1 after reset");

        // R7: linear from 1 -> 1,2,3,0 then wrap to 1 (R10)
        step(0, 0, 1, 1, 0, 20'hABC41, "R2 proc load");
        step(1, 1, 1, 0, 0, 20'h0, "R7 linear beat1");
        step(1, 1, 1, 0, 1, 20'h0, "R9 mode change ignored");
        step(1, 1, 1, 0, 1, 20'h0, "R7 linear beat3");
        step(1, 1, 1, 0, 0, 20'h0, "R10 wrap to start");
        step(1, 1, 1, 1, 0, 20'h0, "R6 hold");

        // R8: interleaved from 1 -> 1,0,3,2 then 1
        step(0, 1, 0, 1, 1, 20'h12345, "R2 cache load");
        for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 0, 20'h0, "R8 interleave");
        // interleaved from 2 -> 2,3,0,1
        step(0, 0, 0, 0, 1, 20'hFFFF6, "R4 load beats advance");
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 0, 20'h0, "R8 interleave start2");

        // R3: strobes with ce_n high ignored
        step(1, 0, 0, 1, 0, 20'h55555, "R3 strobes ignored");
        step(1, 0, 1, 0, 1, 20'h0AAAA, "R3 ignored with advance");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic cen = ($urandom_range(0, 3) == 0);
            logic pn  = ($urandom_range(0, 4) != 0);
            logic cn  = ($urandom_range(0, 4) != 0);
            logic an  = $urandom_range(0, 1) != 0;
            logic md  = $urandom_range(0, 1) != 0;
            logic [AW-1:0] a = AW'($urandom);
            string tag;
            if (!cen && (!pn || !cn)) tag = "R2/R4 random load";
            else if (!an) tag = m_ilv ? "R5/R8 random advance" : "R5/R7 random advance";
            else tag = cen ? "R3/R6 random idle" : "R6 random hold";
            step(cen, pn, cn, an, md, a, tag);
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule